// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This unit is the hazard control for a five-stage in-order integer pipeline: fetch, decode, execute, memory, writeback. Registers are read in decode and written in writeback, and every instruction passes through all five stages. Because of that, only read-after-write conflicts can arise. The unit is purely combinational. It looks at the source register numbers of the instruction in execute and at the destinations and write enables of the two older instructions in memory and writeback. From these it sets the select lines of the three-way operand multiplexers in front of the ALU and of the store-data path.

The unit also handles the one dependence that forwarding alone cannot cover. When a load sits in execute and the instruction in decode needs the loaded register as an address or ALU operand, the unit holds the PC and the fetch/decode register for one cycle and turns the execute-bound slot into a bubble. Once the bubble has passed, the value comes from the memory/writeback register.

A store that only needs a just-loaded register as its data does not stall. Its data is corrected in the memory stage from the memory/writeback register. The register file writes in the first half of a cycle and reads in the second half, so decode sees writeback results directly, and the third instruction after a producer needs nothing from this unit.

Top module: `hazard_fwd_unit`

## Requirements
- R1: `sel_a` picks the source for ALU operand A, which is register `ex_rs`. The codes are 2'b00 for the register file, 2'b10 for the execute/memory result and 2'b01 for the memory/writeback value. The execute/memory result is picked when `mem_dst` equals `ex_rs` with `mem_wen` high. The memory/writeback value is picked when `wb_dst` equals `ex_rs` with `wb_wen` high.
- R2: `sel_b` follows the same rule and codes for ALU operand B, which is register `ex_rt`.
- R3: When both older stages match the same source, the execute/memory result (2'b10) wins.
- R4: Register 0 never matches. A source or destination of 0 gives select 2'b00, and a load into register 0 never stalls.
- R5: A stage whose write enable is low never matches, whatever its destination number.
- R6: When the instruction in execute is a load (`ex_load` and `ex_wen` high, `ex_dst` nonzero) and the decode instruction reads `id_rs` with `id_rd_rs` high, or reads `id_rt` as an ALU operand with `id_rd_rt_alu` high, and that register equals `ex_dst`, then `hold_pc`, `hold_ifid` and `bubble_idex` are all high. After the bubble, the consumer in execute with the load in writeback gets select 2'b01.
- R7: No stall is raised in these cases: the decode instruction uses the loaded register only as store data; the instruction in execute is not a load; or the load is two stages ahead, in memory.
- R8: `sel_sd` selects the store data for register `ex_rt`, using the codes of R1. The execute/memory result is never chosen when that stage holds a load. In that case a matching writeback value (2'b01) or the register file (2'b00) is chosen instead.
- R9: `sd_from_wb` is high when the instruction in memory is a store (`mem_store`) whose data register `mem_src` is nonzero and equals `wb_dst` of a load in writeback with `wb_wen` high. It is low otherwise.
- R10: `hold_pc`, `hold_ifid` and `bubble_idex` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register of the decode instruction |
| id_rd_rs | input | 1 | Decode instruction reads id_rs |
| id_rd_rt_alu | input | 1 | Decode instruction reads id_rt as an ALU operand |
| ex_rs | input | 5 | First source register in the decode/execute register |
| ex_rt | input | 5 | Second source register in the decode/execute register |
| ex_dst | input | 5 | Destination of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_dst | input | 5 | Destination in the execute/memory register |
| mem_wen | input | 1 | Write enable in the execute/memory register |
| mem_load | input | 1 | Instruction in memory is a load |
| mem_store | input | 1 | Instruction in memory is a store |
| mem_src | input | 5 | Store data register of the instruction in memory |
| wb_dst | input | 5 | Destination in the memory/writeback register |
| wb_wen | input | 1 | Write enable in the memory/writeback register |
| wb_load | input | 1 | Instruction in writeback is a load |
| sel_a | output | 2 | ALU operand A source select |
| sel_b | output | 2 | ALU operand B source select |
| sel_sd | output | 2 | Execute-stage store data source select |
| sd_from_wb | output | 1 | Memory-stage store data taken from writeback |
| hold_pc | output | 1 | Keep the PC for this cycle |
| hold_ifid | output | 1 | Keep the fetch/decode register for this cycle |
| bubble_idex | output | 1 | Clear control bits entering execute |

## Verification
The immediate assertions check some invariants on every evaluation. A forward from execute/memory must have a matching enabled destination. Register 0 must always read from the register file. Store data must never be taken from a load still in memory. A stall must only be raised while a load sits in execute. The bench checks the actual select values and the stall decision in chosen pipeline situations: back-to-back ALU dependences, a load followed by an ALU consumer, the consumer after the bubble, load-then-store pairs in both stages, and writes to register 0. It also checks which stage wins when two stages match.

// File: rtl/hfu_pkg.sv
package hfu_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } src_sel_e;
endpackage

// File: rtl/hfu_src_pick.sv
module hfu_src_pick
  import hfu_pkg::*;
#(
  parameter int REG_AW        = 5,
  parameter int SKIP_MEM_LOAD = 0
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  output src_sel_e          sel
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic src_live;
  logic hit_mem;
  logic hit_wb;

  always_comb begin
    src_live = (src != ZERO_REG);
    hit_mem  = src_live && mem_wen && (mem_dst == src);
    if (SKIP_MEM_LOAD != 0) begin
      hit_mem = hit_mem && !mem_load;
    end
    hit_wb   = src_live && wb_wen && (wb_dst == src);
    // younger producer first
    if (hit_mem) begin
      sel = SEL_MEM;
    end else if (hit_wb) begin
      sel = SEL_WB;
    end else begin
      sel = SEL_RF;
    end
  end

  always_comb begin
    if (src == ZERO_REG) begin
      a_r4_zero_reads_rf: assert (sel == SEL_RF);
    end
    if (sel == SEL_WB) begin
      a_r5_wb_needs_wen: assert (wb_wen && wb_dst == src);
    end
  end
endmodule

// File: rtl/hfu_load_use.sv
module hfu_load_use #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_rd_rs,
  input  logic              id_rd_rt_alu,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic              ex_load,
  output logic              stall
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic load_pending;
  logic dep_rs;
  logic dep_rt;

  always_comb begin
    load_pending = ex_load && ex_wen && (ex_dst != ZERO_REG);
    dep_rs       = id_rd_rs && (id_rs == ex_dst);
    dep_rt       = id_rd_rt_alu && (id_rt == ex_dst);
    stall        = load_pending && (dep_rs || dep_rt);
  end
endmodule

// File: rtl/hfu_store_late.sv
module hfu_store_late #(
  parameter int REG_AW = 5
) (
  input  logic              mem_store,
  input  logic [REG_AW-1:0] mem_src,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  input  logic              wb_load,
  output logic              late
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  always_comb begin
    late = mem_store && wb_load && wb_wen &&
           (mem_src != ZERO_REG) && (mem_src == wb_dst);
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hfu_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_rd_rs,
  input  logic              id_rd_rt_alu,
  input  logic [REG_AW-1:0] ex_rs,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic              mem_load,
  input  logic              mem_store,
  input  logic [REG_AW-1:0] mem_src,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  input  logic              wb_load,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [1:0]        sel_sd,
  output logic              sd_from_wb,
  output logic              hold_pc,
  output logic              hold_ifid,
  output logic              bubble_idex
);
  // lane 0: ALU A, lane 1: ALU B, lane 2: store data
  localparam int NLANE   = 3;
  localparam int SD_LANE = NLANE - 1;

  logic [REG_AW-1:0] lane_src [NLANE];
  src_sel_e          lane_sel [NLANE];
  logic              stall;

  assign lane_src[0] = ex_rs;
  assign lane_src[1] = ex_rt;
  assign lane_src[2] = ex_rt;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    hfu_src_pick #(
      .REG_AW       (REG_AW),
      .SKIP_MEM_LOAD((g == SD_LANE) ? 1 : 0)
    ) u_pick (
      .src     (lane_src[g]),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .mem_load(mem_load),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .sel     (lane_sel[g])
    );
  end

  hfu_load_use #(.REG_AW(REG_AW)) u_lu (
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .id_rd_rs    (id_rd_rs),
    .id_rd_rt_alu(id_rd_rt_alu),
    .ex_dst      (ex_dst),
    .ex_wen      (ex_wen),
    .ex_load     (ex_load),
    .stall       (stall)
  );

  hfu_store_late #(.REG_AW(REG_AW)) u_sl (
    .mem_store(mem_store),
    .mem_src  (mem_src),
    .wb_dst   (wb_dst),
    .wb_wen   (wb_wen),
    .wb_load  (wb_load),
    .late     (sd_from_wb)
  );

  assign sel_a       = lane_sel[0];
  assign sel_b       = lane_sel[1];
  assign sel_sd      = lane_sel[SD_LANE];
  assign hold_pc     = stall;
  assign hold_ifid   = stall;
  assign bubble_idex = stall;

  always_comb begin
    if (sel_a == SEL_MEM) begin
      a_r1_mem_fwd_matches: assert (mem_wen && mem_dst == ex_rs && ex_rs != '0);
    end
    if (sel_sd == SEL_MEM) begin
      a_r8_sd_not_from_load: assert (!mem_load);
    end
    if (hold_pc) begin
      a_r6_stall_has_load: assert (ex_load && ex_wen && ex_dst != '0);
    end
    if (sd_from_wb) begin
      a_r9_late_needs_store: assert (mem_store && wb_load);
    end
    a_r10_stall_agree: assert (hold_ifid == bubble_idex && hold_pc == hold_ifid);
  end
endmodule

// File: tb/sim_hazard_fwd_unit.sv
module sim_hazard_fwd_unit;
  logic clk;
  logic rst_n;
  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, mem_src, wb_dst;
  logic id_rd_rs, id_rd_rt_alu, ex_wen, ex_load, mem_wen, mem_load, mem_store;
  logic wb_wen, wb_load;
  logic [1:0] sel_a, sel_b, sel_sd;
  logic sd_from_wb, hold_pc, hold_ifid, bubble_idex;

  hazard_fwd_unit u0 (
    .id_rs(id_rs), .id_rt(id_rt), .id_rd_rs(id_rd_rs), .id_rd_rt_alu(id_rd_rt_alu),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load), .mem_store(mem_store),
    .mem_src(mem_src), .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_load(wb_load),
    .sel_a(sel_a), .sel_b(sel_b), .sel_sd(sel_sd), .sd_from_wb(sd_from_wb),
    .hold_pc(hold_pc), .hold_ifid(hold_ifid), .bubble_idex(bubble_idex)
  );

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic [1:0] sd;
    logic       late;
    logic       stall;
    string      tag;
  } exp_t;

  exp_t scb [$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  task automatic idle();
    id_rs = '0; id_rt = '0; id_rd_rs = 1'b0; id_rd_rt_alu = 1'b0;
    ex_rs = '0; ex_rt = '0; ex_dst = '0; ex_wen = 1'b0; ex_load = 1'b0;
    mem_dst = '0; mem_wen = 1'b0; mem_load = 1'b0; mem_store = 1'b0; mem_src = '0;
    wb_dst = '0; wb_wen = 1'b0; wb_load = 1'b0;
  endtask

  // inputs were set by the caller after the rising edge; push expectation
  task automatic push(input logic [1:0] a, input logic [1:0] b, input logic [1:0] sd,
                      input logic late, input logic stall, input string tag);
    exp_t e;
    e.a = a; e.b = b; e.sd = sd; e.late = late; e.stall = stall; e.tag = tag;
    scb.push_back(e);
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (rst_n && scb.size() > 0) begin
      exp_t e;
      e = scb.pop_front();
      cmp(e.tag, "sel_a", sel_a, e.a);
      cmp(e.tag, "sel_b", sel_b, e.b);
      cmp(e.tag, "sel_sd", sel_sd, e.sd);
      cmp(e.tag, "sd_from_wb", sd_from_wb, e.late);
      cmp(e.tag, "hold_pc", hold_pc, e.stall);
      cmp({e.tag, " R10"}, "hold_ifid", hold_ifid, e.stall);
      cmp({e.tag, " R10"}, "bubble_idex", bubble_idex, e.stall);
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset / idle state
    push(2'b00, 2'b00, 2'b00, 1'b0, 1'b0, "R5 idle");
    // R1 back-to-back ALU: producer in memory
    ex_rs = 5'd3; mem_dst = 5'd3; mem_wen = 1'b1;
    push(2'b10, 2'b00, 2'b00, 1'b0, 1'b0, "R1 exmem");
    // R2 operand B and store data from writeback
    ex_rt = 5'd4; wb_dst = 5'd4; wb_wen = 1'b1;
    push(2'b00, 2'b01, 2'b01, 1'b0, 1'b0, "R2 memwb");
    // R3 both stages match
    ex_rs = 5'd5; ex_rt = 5'd5; mem_dst = 5'd5; mem_wen = 1'b1; wb_dst = 5'd5; wb_wen = 1'b1;
    push(2'b10, 2'b10, 2'b10, 1'b0, 1'b0, "R3 younger");
    // R4 register 0
    ex_rs = 5'd0; ex_rt = 5'd0; mem_dst = 5'd0; mem_wen = 1'b1; wb_dst = 5'd0; wb_wen = 1'b1;
    push(2'b00, 2'b00, 2'b00, 1'b0, 1'b0, "R4 zero");
    // R5 write enables low
    ex_rs = 5'd6; ex_rt = 5'd6; mem_dst = 5'd6; wb_dst = 5'd6;
    push(2'b00, 2'b00, 2'b00, 1'b0, 1'b0, "R5 no wen");
    // R6 load-use via rs
    ex_load = 1'b1; ex_wen = 1'b1; ex_dst = 5'd7; id_rs = 5'd7; id_rd_rs = 1'b1;
    push(2'b00, 2'b00, 2'b00, 1'b0, 1'b1, "R6 rs");
    // R6 load-use via rt as ALU operand
    ex_load = 1'b1; ex_wen = 1'b1; ex_dst = 5'd7; id_rt = 5'd7; id_rd_rt_alu = 1'b1;
    id_rs = 5'd2; id_rd_rs = 1'b1;
    push(2'b00, 2'b00, 2'b00, 1'b0, 1'b1, "R6 rt");
    // R7 store data only
    ex_load = 1'b1; ex_wen = 1'b1; ex_dst = 5'd7; id_rt = 5'd7; id_rs = 5'd2; id_rd_rs = 1'b1;
    push(2'b00, 2'b00, 2'b00, 1'b0, 1'b0, "R7 store data");
    // R7 not a load
    ex_wen = 1'b1; ex_dst = 5'd7; id_rs = 5'd7; id_rd_rs = 1'b1;
    push(2'b00, 2'b00, 2'b00, 1'b0, 1'b0, "R7 alu producer");
    // R4 load into register 0
    ex_load = 1'b1; ex_wen = 1'b1; ex_dst = 5'd0; id_rs = 5'd0; id_rd_rs = 1'b1;
    push(2'b00, 2'b00, 2'b00, 1'b0, 1'b0, "R4 load r0");
    // R7 load two ahead
    mem_load = 1'b1; mem_wen = 1'b1; mem_dst = 5'd7; id_rs = 5'd7; id_rd_rs = 1'b1;
    push(2'b00, 2'b00, 2'b00, 1'b0, 1'b0, "R7 load in mem");
    // R6 after bubble: load in writeback
    wb_load = 1'b1; wb_wen = 1'b1; wb_dst = 5'd7; ex_rs = 5'd7;
    push(2'b01, 2'b00, 2'b00, 1'b0, 1'b0, "R6 after bubble");
    // R8 load in memory, store in execute
    mem_load = 1'b1; mem_wen = 1'b1; mem_dst = 5'd9; ex_rt = 5'd9;
    push(2'b00, 2'b10, 2'b00, 1'b0, 1'b0, "R8 skip load");
    // R8 older writeback match used instead
    mem_load = 1'b1; mem_wen = 1'b1; mem_dst = 5'd9; ex_rt = 5'd9; wb_dst = 5'd9; wb_wen = 1'b1;
    push(2'b00, 2'b10, 2'b01, 1'b0, 1'b0, "R8 wb fallback");
    // R9 late store data
    mem_store = 1'b1; mem_src = 5'd9; wb_dst = 5'd9; wb_wen = 1'b1; wb_load = 1'b1;
    push(2'b00, 2'b00, 2'b00, 1'b1, 1'b0, "R9 late");
    // R9 writeback not enabled
    mem_store = 1'b1; mem_src = 5'd9; wb_dst = 5'd9; wb_load = 1'b1;
    push(2'b00, 2'b00, 2'b00, 1'b0, 1'b0, "R9 no wen");
    // R9 data register 0
    mem_store = 1'b1; mem_src = 5'd0; wb_dst = 5'd0; wb_wen = 1'b1; wb_load = 1'b1;
    push(2'b00, 2'b00, 2'b00, 1'b0, 1'b0, "R9 r0");

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule